// File: doc/BRIEF.md
# Hardwired Single-Bus Control Sequencer

This block is the control unit of a 32-bit load/store processor in which every register transfer goes over one shared bus. A step counter, the opcode field of the instruction register and a few status flags select, in each clock cycle, a set of transfer strobes. The strobes say which register drives the bus, which registers capture it, which ALU function applies and whether memory is asked to read or write. The datapath, the ALU and memory sit outside the block and see only these strobes.

Every instruction begins with a three-step fetch. An execute schedule follows, chosen by the opcode: register add, immediate add, load, store, conditional branch, serial right shift, no-operation and halt. A stall strobe freezes the sequence until memory reports completion. An end strobe sends the counter back to the fetch. The shift schedule repeats one step for each bit position. A run flag gates the whole sequence: after reset or a halt, the block stays quiet until it sees a start request.

Top module: `ctl_seq_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with `start` low, `step` is 0, `run` is 0 and every bit of `strobe` is 0.
- R2: While `run` is 0, `step` stays 0 and every strobe is 0, except PC_CLR (bit 28), which equals `start`. A cycle with `start` high sets `run` on the next clock.
- R3: With `run` set, step 0 asserts exactly PC_OUT(0), MA_IN(1), INC4(2) and C_IN(3). Step 1 asserts RD(4), C_OUT(5), PC_IN(6) and WAIT(7). Step 2 asserts MD_OUT(8) and IR_IN(9). None of these depends on `opcode`.
- R4: When WAIT(7) is asserted and `mem_done` is low, `step` and `strobe` hold their values on the next clock.
- R5: When END(27) is asserted and no stall is pending, `step` is 0 on the next clock. Otherwise a non-stalled step advances by one, except in the shift loop (R11).
- R6: For opcode 12 (register add), steps 3 to 5 assert: {SEL_RB(10), REG_OUT(13), A_IN(15)}, then {SEL_RC(11), REG_OUT, ALU_ADD(16), C_IN}, then {C_OUT, SEL_RA(12), REG_IN(14), END}.
- R7: For opcode 13 (immediate add), steps 3 to 5 match R6, except that step 4 asserts {C2_OUT(17), ALU_ADD, C_IN}.
- R8: For opcode 1 (load), steps 3 to 7 assert: {SEL_RB, BASE_OUT(18), A_IN}, {C2_OUT, ALU_ADD, C_IN}, {C_OUT, MA_IN}, {RD, WAIT}, {MD_OUT, SEL_RA, REG_IN, END}.
- R9: For opcode 3 (store), steps 3 to 5 match R8. Step 6 asserts {SEL_RA, REG_OUT, MD_IN(20), WR(19)} and step 7 asserts {WAIT, END}.
- R10: For opcode 8 (branch), step 3 asserts {SEL_RC, REG_OUT, CON_IN(21)}. Step 4 asserts {SEL_RB, REG_OUT, END}, and PC_IN only when `cond_flag` is high.
- R11: For opcode 26 (right shift):
  - step 3 asserts {C1_OUT(22), CNT_LD(23)};
  - step 4 asserts {SEL_RC, REG_OUT, CNT_LD} only when `cnt_zero` is high, and nothing otherwise;
  - step 5 asserts {SEL_RB, REG_OUT, PASS_B(24), C_IN};
  - step 6, while `cnt_zero` is low, asserts {C_OUT, SHR(25), C_IN, CNT_DEC(26)} and stays at step 6; once `cnt_zero` is high it asserts nothing and advances;
  - step 7 asserts {C_OUT, SEL_RA, REG_IN, END}.
- R12: Opcode 31 (halt), opcode 0 and any unlisted opcode assert only END at step 3. Halt also clears `run` on that clock.
- R13: At most one bus source (PC_OUT, C_OUT, MD_OUT, REG_OUT, C2_OUT, BASE_OUT, C1_OUT) is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, used while halted |
| opcode | input | 5 | Operation field of the instruction register |
| mem_done | input | 1 | Memory completion handshake |
| cond_flag | input | 1 | Latched branch condition |
| cnt_zero | input | 1 | Shift count register equals zero |
| strobe | output | 29 | Register-transfer strobes, bit layout as in the requirements |
| step | output | 3 | Current control step |
| run | output | 1 | Run flag |

## Verification
The assertions assume that `opcode` is steady from step 3 until END of each instruction, that `cnt_zero` reflects the count register as the strobes update it, and that `mem_done` is meaningful only while WAIT is asserted. The stimulus holds the opcode for the whole instruction. It derives `cnt_zero` from a shift count kept in the bench, which CNT_LD loads and CNT_DEC decrements. It raises `mem_done` only after a chosen number of stalled cycles, from zero to three.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int OP_W   = 5;
  localparam int STEP_W = 3;
  localparam int NSTB   = 29;

  localparam logic [OP_W-1:0] OP_NOP  = 5'd0;
  localparam logic [OP_W-1:0] OP_LD   = 5'd1;
  localparam logic [OP_W-1:0] OP_ST   = 5'd3;
  localparam logic [OP_W-1:0] OP_BR   = 5'd8;
  localparam logic [OP_W-1:0] OP_ADD  = 5'd12;
  localparam logic [OP_W-1:0] OP_ADDI = 5'd13;
  localparam logic [OP_W-1:0] OP_SHR  = 5'd26;
  localparam logic [OP_W-1:0] OP_STOP = 5'd31;

  localparam logic [STEP_W-1:0] LOOP_STEP = 3'd6;
  localparam logic [STEP_W-1:0] EXEC_STEP = 3'd3;

  // strobe bit positions
  localparam int S_PC_OUT   = 0;
  localparam int S_MA_IN    = 1;
  localparam int S_INC4     = 2;
  localparam int S_C_IN     = 3;
  localparam int S_RD       = 4;
  localparam int S_C_OUT    = 5;
  localparam int S_PC_IN    = 6;
  localparam int S_WAIT     = 7;
  localparam int S_MD_OUT   = 8;
  localparam int S_IR_IN    = 9;
  localparam int S_SEL_RB   = 10;
  localparam int S_SEL_RC   = 11;
  localparam int S_SEL_RA   = 12;
  localparam int S_REG_OUT  = 13;
  localparam int S_REG_IN   = 14;
  localparam int S_A_IN     = 15;
  localparam int S_ALU_ADD  = 16;
  localparam int S_C2_OUT   = 17;
  localparam int S_BASE_OUT = 18;
  localparam int S_WR       = 19;
  localparam int S_MD_IN    = 20;
  localparam int S_CON_IN   = 21;
  localparam int S_C1_OUT   = 22;
  localparam int S_CNT_LD   = 23;
  localparam int S_PASS_B   = 24;
  localparam int S_SHR      = 25;
  localparam int S_CNT_DEC  = 26;
  localparam int S_END      = 27;
  localparam int S_PC_CLR   = 28;

  // next step: stall holds, end restarts, loop repeats, else advance
  function automatic logic [STEP_W-1:0] step_after(input logic [STEP_W-1:0] cur,
                                                   input logic stall, input logic fin,
                                                   input logic loop);
    if (stall)     return cur;
    else if (fin)  return '0;
    else if (loop) return cur;
    else           return cur + 1'b1;
  endfunction

  // mask of sources that may drive the shared bus
  function automatic logic [NSTB-1:0] bus_sources(input logic [NSTB-1:0] s);
    logic [NSTB-1:0] m;
    m = '0;
    m[S_PC_OUT] = 1'b1; m[S_C_OUT] = 1'b1; m[S_MD_OUT] = 1'b1; m[S_REG_OUT] = 1'b1;
    m[S_C2_OUT] = 1'b1; m[S_BASE_OUT] = 1'b1; m[S_C1_OUT] = 1'b1;
    return s & m;
  endfunction
endpackage

// File: rtl/ctl_seq_decode.sv
module ctl_seq_decode
  import ctl_seq_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int STW  = STEP_W,
  parameter int NS   = NSTB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           start,
  input  logic [STW-1:0] step,
  input  logic [OPW-1:0] opcode,
  input  logic           mem_done,
  input  logic           cond_flag,
  input  logic           cnt_zero,
  output logic [NS-1:0]  strobe,
  output logic           stall,
  output logic           fin,
  output logic           loop,
  output logic           stop_hit
);
  logic [NS-1:0] s;
  logic [NS-1:0] bus_now;

  always_comb begin
    s = '0;
    if (!run) begin
      s[S_PC_CLR] = start;
    end else begin
      case (step)
        3'd0: begin s[S_PC_OUT] = 1'b1; s[S_MA_IN] = 1'b1; s[S_INC4] = 1'b1; s[S_C_IN] = 1'b1; end
        3'd1: begin s[S_RD] = 1'b1; s[S_C_OUT] = 1'b1; s[S_PC_IN] = 1'b1; s[S_WAIT] = 1'b1; end
        3'd2: begin s[S_MD_OUT] = 1'b1; s[S_IR_IN] = 1'b1; end
        default: begin
          case (opcode)
            OP_ADD, OP_ADDI: begin
              case (step)
                3'd3: begin s[S_SEL_RB] = 1'b1; s[S_REG_OUT] = 1'b1; s[S_A_IN] = 1'b1; end
                3'd4: begin
                  if (opcode == OP_ADD) begin s[S_SEL_RC] = 1'b1; s[S_REG_OUT] = 1'b1; end
                  else s[S_C2_OUT] = 1'b1;
                  s[S_ALU_ADD] = 1'b1; s[S_C_IN] = 1'b1;
                end
                3'd5: begin s[S_C_OUT] = 1'b1; s[S_SEL_RA] = 1'b1; s[S_REG_IN] = 1'b1; s[S_END] = 1'b1; end
                default: s = '0;
              endcase
            end
            OP_LD, OP_ST: begin
              case (step)
                3'd3: begin s[S_SEL_RB] = 1'b1; s[S_BASE_OUT] = 1'b1; s[S_A_IN] = 1'b1; end
                3'd4: begin s[S_C2_OUT] = 1'b1; s[S_ALU_ADD] = 1'b1; s[S_C_IN] = 1'b1; end
                3'd5: begin s[S_C_OUT] = 1'b1; s[S_MA_IN] = 1'b1; end
                3'd6: begin
                  if (opcode == OP_LD) begin s[S_RD] = 1'b1; s[S_WAIT] = 1'b1; end
                  else begin s[S_SEL_RA] = 1'b1; s[S_REG_OUT] = 1'b1; s[S_MD_IN] = 1'b1; s[S_WR] = 1'b1; end
                end
                default: begin
                  if (opcode == OP_LD) begin
                    s[S_MD_OUT] = 1'b1; s[S_SEL_RA] = 1'b1; s[S_REG_IN] = 1'b1; s[S_END] = 1'b1;
                  end else begin
                    s[S_WAIT] = 1'b1; s[S_END] = 1'b1;
                  end
                end
              endcase
            end
            OP_BR: begin
              if (step == 3'd3) begin
                s[S_SEL_RC] = 1'b1; s[S_REG_OUT] = 1'b1; s[S_CON_IN] = 1'b1;
              end else if (step == 3'd4) begin
                s[S_SEL_RB] = 1'b1; s[S_REG_OUT] = 1'b1; s[S_PC_IN] = cond_flag; s[S_END] = 1'b1;
              end
            end
            OP_SHR: begin
              case (step)
                3'd3: begin s[S_C1_OUT] = 1'b1; s[S_CNT_LD] = 1'b1; end
                3'd4: begin
                  s[S_SEL_RC] = cnt_zero; s[S_REG_OUT] = cnt_zero; s[S_CNT_LD] = cnt_zero;
                end
                3'd5: begin s[S_SEL_RB] = 1'b1; s[S_REG_OUT] = 1'b1; s[S_PASS_B] = 1'b1; s[S_C_IN] = 1'b1; end
                3'd6: begin
                  s[S_C_OUT] = !cnt_zero; s[S_SHR] = !cnt_zero; s[S_C_IN] = !cnt_zero; s[S_CNT_DEC] = !cnt_zero;
                end
                default: begin s[S_C_OUT] = 1'b1; s[S_SEL_RA] = 1'b1; s[S_REG_IN] = 1'b1; s[S_END] = 1'b1; end
              endcase
            end
            default: begin
              if (step == EXEC_STEP) s[S_END] = 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  assign strobe   = s;
  assign bus_now  = bus_sources(s);
  assign stall    = run && s[S_WAIT] && !mem_done;
  assign fin      = run && s[S_END];
  assign loop     = run && (step == LOOP_STEP) && (opcode == OP_SHR) && !cnt_zero;
  assign stop_hit = run && (step == EXEC_STEP) && (opcode == OP_STOP);

  p_one_source_r13: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_now) <= 1);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |-> (strobe == '0));
  p_br_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (run && step == 3'd4 && opcode == OP_BR && !cond_flag) |-> !strobe[S_PC_IN]);
endmodule

// File: rtl/ctl_seq_step.sv
module ctl_seq_step
  import ctl_seq_pkg::*;
#(
  parameter int STW = STEP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           stall,
  input  logic           fin,
  input  logic           loop,
  input  logic           stop_hit,
  output logic [STW-1:0] step,
  output logic           run
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      run  <= 1'b0;
    end else if (!run) begin
      step <= '0;
      run  <= start;
    end else begin
      step <= step_after(step, stall, fin, loop);
      run  <= !stop_hit;
    end
  end

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(step));
  p_end_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (fin && !stall) |=> (step == '0));
  p_halt_r12: assert property (@(posedge clk) disable iff (rst)
    stop_hit |=> !run);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && start) |=> (run && step == '0));
endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
  import ctl_seq_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int STW = STEP_W,
  parameter int NS  = NSTB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic           mem_done,
  input  logic           cond_flag,
  input  logic           cnt_zero,
  output logic [NS-1:0]  strobe,
  output logic [STW-1:0] step,
  output logic           run
);
  logic stall_w, fin_w, loop_w, stop_w;

  ctl_seq_decode #(.OPW(OPW), .STW(STW), .NS(NS)) u_dec (
    .clk(clk), .rst(rst), .run(run), .start(start), .step(step), .opcode(opcode),
    .mem_done(mem_done), .cond_flag(cond_flag), .cnt_zero(cnt_zero),
    .strobe(strobe), .stall(stall_w), .fin(fin_w), .loop(loop_w), .stop_hit(stop_w)
  );

  ctl_seq_step #(.STW(STW)) u_step (
    .clk(clk), .rst(rst), .start(start), .stall(stall_w), .fin(fin_w),
    .loop(loop_w), .stop_hit(stop_w), .step(step), .run(run)
  );

  p_fetch_free_r3: assert property (@(posedge clk) disable iff (rst)
    (run && step == 3'd0) |-> (strobe[S_PC_OUT] && strobe[S_INC4] && !strobe[S_END]));
endmodule

// File: tb/ctl_seq_top_test.sv
module ctl_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // strobe positions as given in the requirements
  localparam int PC_OUT = 0, MA_IN = 1, INC4 = 2, C_IN = 3, RD = 4, C_OUT = 5, PC_IN = 6;
  localparam int WAITB = 7, MD_OUT = 8, IR_IN = 9, SEL_RB = 10, SEL_RC = 11, SEL_RA = 12;
  localparam int REG_OUT = 13, REG_IN = 14, A_IN = 15, ALU_ADD = 16, C2_OUT = 17;
  localparam int BASE_OUT = 18, WR = 19, MD_IN = 20, CON_IN = 21, C1_OUT = 22;
  localparam int CNT_LD = 23, PASS_B = 24, SHRB = 25, CNT_DEC = 26, ENDB = 27, PC_CLR = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  opcode = 5'd0;
  logic        mem_done = 1'b0;
  logic        cond_flag = 1'b0;
  logic        cnt_zero = 1'b1;
  logic [28:0] strobe;
  logic [2:0]  step;
  logic        run;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int m_step = 0;
  bit m_run = 1'b0;
  int m_cnt = 0;
  int wait_seen = 0;
  int mem_delay = 0;
  int shamt = 0;
  int rc_amt = 0;

  ctl_seq_top uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .mem_done(mem_done),
    .cond_flag(cond_flag), .cnt_zero(cnt_zero), .strobe(strobe), .step(step), .run(run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [28:0] on(input int a, input int b = -1, input int c = -1, input int d = -1);
    logic [28:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    return v;
  endfunction

  // expected strobes, organised opcode first
  function automatic logic [28:0] expect_strobes(input int st, input bit rn, input int op,
                                                 input bit strt, input bit cf, input bit cz);
    logic [28:0] v = '0;
    if (!rn) begin v[PC_CLR] = strt; return v; end
    if (st == 0) return on(PC_OUT, MA_IN, INC4, C_IN);
    if (st == 1) return on(RD, C_OUT, PC_IN, WAITB);
    if (st == 2) return on(MD_OUT, IR_IN);
    if (op == 12 || op == 13) begin
      if (st == 3) v = on(SEL_RB, REG_OUT, A_IN);
      if (st == 4) v = (op == 12) ? on(SEL_RC, REG_OUT, ALU_ADD, C_IN) : on(C2_OUT, ALU_ADD, C_IN);
      if (st == 5) v = on(C_OUT, SEL_RA, REG_IN, ENDB);
    end else if (op == 1 || op == 3) begin
      if (st == 3) v = on(SEL_RB, BASE_OUT, A_IN);
      if (st == 4) v = on(C2_OUT, ALU_ADD, C_IN);
      if (st == 5) v = on(C_OUT, MA_IN);
      if (st == 6) v = (op == 1) ? on(RD, WAITB) : on(SEL_RA, REG_OUT, MD_IN, WR);
      if (st == 7) v = (op == 1) ? on(MD_OUT, SEL_RA, REG_IN, ENDB) : on(WAITB, ENDB);
    end else if (op == 8) begin
      if (st == 3) v = on(SEL_RC, REG_OUT, CON_IN);
      if (st == 4) begin v = on(SEL_RB, REG_OUT, ENDB); v[PC_IN] = cf; end
    end else if (op == 26) begin
      if (st == 3) v = on(C1_OUT, CNT_LD);
      if (st == 4 && cz) v = on(SEL_RC, REG_OUT, CNT_LD);
      if (st == 5) v = on(SEL_RB, REG_OUT, PASS_B, C_IN);
      if (st == 6 && !cz) v = on(C_OUT, SHRB, C_IN, CNT_DEC);
      if (st == 7) v = on(C_OUT, SEL_RA, REG_IN, ENDB);
    end else begin
      if (st == 3) v = on(ENDB);
    end
    return v;
  endfunction

  function automatic int bus_count(input logic [28:0] s);
    return int'(s[PC_OUT]) + int'(s[C_OUT]) + int'(s[MD_OUT]) + int'(s[REG_OUT]) +
           int'(s[C2_OUT]) + int'(s[BASE_OUT]) + int'(s[C1_OUT]);
  endfunction

  // one clock: set flags, compare at negedge+1, advance the model at posedge
  task automatic cyc(input string tag);
    logic [28:0] e;
    string t;
    cnt_zero = (m_cnt == 0);
    e = expect_strobes(m_step, m_run, opcode, start, cond_flag, cnt_zero);
    if (e[WAITB] && wait_seen < mem_delay) mem_done = 1'b0;
    else mem_done = 1'b1;
    #1;
    t = tag;
    if (rst) t = "R1";
    else if (!m_run) t = "R2";
    else if (m_step < 3) t = "R3";
    else if (e[WAITB] && !mem_done) t = "R4";
    checks++;
    if ({strobe, step, run} !== {e, 3'(m_step), m_run}) begin
      failures++;
      $display("FAIL %s strobe/step/run actual=%h/%0d/%0d expected=%h/%0d/%0d",
               t, strobe, step, run, e, m_step, m_run);
    end
    checks++;
    if (bus_count(strobe) > 1) begin
      failures++;
      $display("FAIL R13 bus sources actual=%0d expected<=1", bus_count(strobe));
    end
    @(posedge clk);
    if (rst) begin
      m_step = 0; m_run = 1'b0;
    end else if (!m_run) begin
      m_step = 0; m_run = start;
    end else if (e[WAITB] && !mem_done) begin
      wait_seen++;
    end else begin
      if (e[WAITB]) wait_seen = 0;
      if (e[ENDB]) begin
        if (m_step == 3 && opcode == 5'd31) m_run = 1'b0;
        m_step = 0;
      end else if (!(m_step == 6 && opcode == 5'd26 && !cnt_zero)) begin
        m_step = m_step + 1;
      end
    end
    if (e[CNT_LD] && e[C1_OUT]) m_cnt = shamt;
    if (e[CNT_LD] && e[REG_OUT]) m_cnt = rc_amt;
    if (e[CNT_DEC]) m_cnt = m_cnt - 1;
    @(negedge clk);
  endtask

  task automatic instr(input int op, input string tag, input int dly, input bit cf,
                       input int sa, input int ra);
    opcode = 5'(op); mem_delay = dly; cond_flag = cf; shamt = sa; rc_amt = ra;
    wait_seen = 0;
    cyc(tag);
    while (m_step != 0) cyc(tag);
    // R5: after END the counter is back at step 0
    #1;
    checks++;
    if (step !== 3'd0) begin
      failures++;
      $display("FAIL R5 step after end actual=%0d expected=0", step);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1 reset state
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    cyc("R1");
    // R2 idle without start
    cyc("R2"); cyc("R2");
    start = 1'b1;
    cyc("R2");
    start = 1'b0;
    instr(0,  "R12", 0, 1'b0, 0, 0);
    instr(12, "R6",  0, 1'b0, 0, 0);
    instr(12, "R6",  2, 1'b0, 0, 0);
    instr(13, "R7",  1, 1'b0, 0, 0);
    instr(1,  "R8",  3, 1'b0, 0, 0);
    instr(3,  "R9",  2, 1'b0, 0, 0);
    instr(3,  "R9",  0, 1'b0, 0, 0);
    instr(8,  "R10", 0, 1'b1, 0, 0);
    instr(8,  "R10", 1, 1'b0, 0, 0);
    instr(26, "R11", 0, 1'b0, 3, 0);
    instr(26, "R11", 0, 1'b0, 0, 2);
    instr(26, "R11", 1, 1'b0, 0, 0);
    instr(20, "R12", 0, 1'b0, 0, 0);
    instr(31, "R12", 0, 1'b0, 0, 0);
    // halted: quiet until start
    cyc("R2"); cyc("R2");
    start = 1'b1;
    cyc("R2");
    start = 1'b0;
    instr(13, "R7", 0, 1'b0, 0, 0);
    // reset in mid-instruction
    opcode = 5'd1;
    cyc("R8"); cyc("R8");
    rst = 1'b1;
    cyc("R1");
    rst = 1'b0;
    cyc("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule